// File: doc/BRIEF.md
# Receive Buffer Resource Ring Manager

This block keeps track of where incoming frames may be stored. Software places a circular table of buffer resources in memory. Each resource is four 16-bit words: the low half of the buffer address, the high half of the buffer address, the low half of the buffer size in 16-bit words, and the high half of that size. The block reads one resource at a time through a word-read memory port. It then holds the current buffer pointer and the number of words left in that buffer.

For each arriving frame, the frame logic presents the frame length in bytes. The block works out the aligned space the frame needs, including the 4 checksum bytes. It either reserves that space or refuses the frame because it does not fit. On each decision it reports whether the frame was stored, whether it was the last one for the current buffer, the packet pointer and the length. When a buffer runs low, the block moves on to the next resource. If the ring read pointer has caught up with the software write pointer, it stops and waits for software to give it more.

The host programs the ring through a small register port. The same port is used to clear status bits, to order a resource read, and to preset the sequence counter.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the following are all zero: read pointer, buffer pointer, word count, sequence counter, both status bits and the blocked flag. `frm_ready` is 1. The end-of-buffer threshold resets to 0x02F8.
- R2: Register writes use `reg_sel` 0 = ring start, 1 = ring end, 2 = read pointer, 3 = write pointer, 4 = end-of-buffer threshold. A pointer write stores the value with bit 0 cleared when `mode_wide`=0, and with bits 1:0 cleared when `mode_wide`=1.
- R3: A resource read fetches four words at read pointer + k·2 (16-bit mode) or + k·4 (32-bit mode), for k = 0..3. The buffer pointer becomes {word1, word0} and the word count becomes {word3, word2}.
- R4: After a resource read, the read pointer advances by 8 bytes (16-bit mode) or 16 bytes (32-bit mode). If the result equals the ring end, it is replaced by the ring start.
- R5: If the read pointer after the advance (and any wrap) equals the write pointer, status bit 5 (exhausted) is set.
- R6: The reported length `pkt_len` is the frame length + 4. The space used is that value rounded up to a multiple of 2 bytes (16-bit mode) or of 4 bytes (32-bit mode).
- R7: If the padded length exceeds twice the word count, the frame is not stored. Status bit 4 (overflow) and the last flag are set, and the buffer pointer and word count stay unchanged.
- R8: A stored frame does the following: `pkt_ptr` takes the buffer pointer as it was before the frame; the buffer pointer grows by the padded length; the word count drops by half the padded length; the low byte of the sequence counter increments modulo 256 while the high byte is kept. A write with `reg_sel`=7 loads the sequence counter.
- R9: A stored frame that leaves a word count below the threshold reports the last flag.
- R10: When a frame ends with the last flag set, the block blocks if the read pointer equals the write pointer, and otherwise reads the next resource at once. While blocked, frames are answered with stored=0 and last=0 and change nothing.
- R11: A status write (`reg_sel`=5, write 1 to clear) that clears bit 5 while it is set reads a resource and unblocks. So does a command write (`reg_sel`=6, bit 0). Clearing only bit 4 starts no read.
- R12: `frm_done` pulses in the cycle after a request is accepted (`frm_req` and `frm_ready` both high). `mem_req` stays high with a stable `mem_addr` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_wide | input | 1 | 1 = 32-bit memory word mode, 0 = 16-bit |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 16 | Byte address of the word to read |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 16 | Read data |
| frm_req | input | 1 | Frame arrival, with length |
| frm_len | input | LEN_W | Frame length in bytes, without checksum |
| frm_ready | output | 1 | Frame requests accepted |
| frm_done | output | 1 | Decision pulse |
| frm_stored | output | 1 | Frame space reserved |
| frm_last | output | 1 | Last frame for this buffer |
| pkt_ptr | output | 32 | Start address of the stored frame |
| pkt_len | output | LEN_W+1 | Frame length plus checksum |
| seq_no | output | 16 | Receive sequence counter |
| buf_ptr | output | 32 | Current buffer pointer |
| buf_words | output | 32 | Remaining words in the buffer |
| rd_ptr | output | 16 | Ring read pointer |
| stat_overflow | output | 1 | Status bit 4, frame did not fit |
| stat_exhaust | output | 1 | Status bit 5, ring exhausted |
| rx_blocked | output | 1 | Reception waiting for a resource |

## Verification
The bench works through a four-entry ring in 16-bit mode with these frame patterns:
- Even and odd lengths, which separate the 2-byte padding from no padding.
- A frame that leaves the count just above the threshold, and one that leaves it just below, which shows where the last flag is decided.
- A frame too large for a small buffer, which separates the overflow path from the store path.
- A read that lands on the write pointer, so exhaustion, blocking, dropped frames and the two status-clear cases (one that reads a resource and one that does not) are all reached.
- A read from the last entry, which exercises the wrap.

A sequence preset near 0xFF shows that the low byte wraps while the high byte is kept. The run then switches to 32-bit mode with misaligned pointer writes and odd lengths, which separates the 4-byte rules from the 2-byte ones.

// File: rtl/rx_ring_pkg.sv
`timescale 1ns/1ps
package rx_ring_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned WIDE_W = 2 * WORD_W;

  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_END   = 3'd1;
  localparam logic [2:0] SEL_RDP   = 3'd2;
  localparam logic [2:0] SEL_WRP   = 3'd3;
  localparam logic [2:0] SEL_EOB   = 3'd4;
  localparam logic [2:0] SEL_STAT  = 3'd5;
  localparam logic [2:0] SEL_CMD   = 3'd6;
  localparam logic [2:0] SEL_SEQ   = 3'd7;

  localparam int unsigned ST_OVF_BIT = 4;
  localparam int unsigned ST_EXH_BIT = 5;

  typedef enum logic {FS_IDLE, FS_READ} fetch_state_e;
endpackage

// File: rtl/rx_ring_ptrs.sv
`timescale 1ns/1ps
module rx_ring_ptrs
  import rx_ring_pkg::*;
#(
  parameter logic [WORD_W-1:0] EOB_RESET = 16'h02F8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              adv,
  output logic [WORD_W-1:0] rd_ptr,
  output logic [WORD_W-1:0] wr_ptr,
  output logic [WORD_W-1:0] eob,
  output logic              exhaust_evt
);
  logic [WORD_W-1:0] start_q, end_q, rd_q, wr_q, eob_q;
  logic [WORD_W-1:0] wr_masked, rd_adv, rd_nxt, entry_bytes;

  // pointers stay aligned to the memory word size
  assign wr_masked   = wide ? (wr_data & ~WORD_W'(3)) : (wr_data & ~WORD_W'(1));
  assign entry_bytes = wide ? WORD_W'(16) : WORD_W'(8);
  assign rd_adv      = rd_q + entry_bytes;
  assign rd_nxt      = (rd_adv == end_q) ? start_q : rd_adv;
  assign exhaust_evt = adv && (rd_nxt == wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      eob_q   <= EOB_RESET;
    end else begin
      if (adv) rd_q <= rd_nxt;
      else if (wr_en && wr_sel == SEL_RDP) rd_q <= wr_masked;
      if (wr_en && wr_sel == SEL_START) start_q <= wr_masked;
      if (wr_en && wr_sel == SEL_END)   end_q   <= wr_masked;
      if (wr_en && wr_sel == SEL_WRP)   wr_q    <= wr_masked;
      if (wr_en && wr_sel == SEL_EOB)   eob_q   <= wr_data;
    end
  end

  assign rd_ptr = rd_q;
  assign wr_ptr = wr_q;
  assign eob    = eob_q;

  assert_wrap_to_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rd_adv == end_q) |=> (rd_q == $past(start_q)));
  assert_advance_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rd_adv != end_q) |=> (rd_q == $past(rd_q) + $past(entry_bytes)));
endmodule

// File: rtl/rx_ring_fetch.sv
`timescale 1ns/1ps
module rx_ring_fetch
  import rx_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wide,
  input  logic [WORD_W-1:0] base,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [WIDE_W-1:0] res_addr,
  output logic [WIDE_W-1:0] res_count
);
  localparam int unsigned IDX_W = 2;

  fetch_state_e      state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q;
  logic              last_word;

  assign busy      = (state_q == FS_READ);
  assign mem_req   = busy;
  assign mem_addr  = base + (WORD_W'(idx_q) << (wide ? 2 : 1));
  assign last_word = (idx_q == IDX_W'(3));
  assign done      = busy && mem_ack && last_word;
  assign res_addr  = {w1_q, w0_q};
  assign res_count = {mem_rdata, w2_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
    end else if (state_q == FS_IDLE) begin
      if (start) begin
        state_q <= FS_READ;
        idx_q   <= '0;
      end
    end else if (mem_ack) begin
      case (idx_q)
        2'd0: w0_q <= mem_rdata;
        2'd1: w1_q <= mem_rdata;
        2'd2: w2_q <= mem_rdata;
        default: ;
      endcase
      idx_q <= idx_q + IDX_W'(1);
      if (last_word) state_q <= FS_IDLE;
    end
  end

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/rx_ring_acct.sv
`timescale 1ns/1ps
module rx_ring_acct
  import rx_ring_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide,
  input  logic [WORD_W-1:0] eob,
  input  logic              load,
  input  logic [WIDE_W-1:0] load_addr,
  input  logic [WIDE_W-1:0] load_count,
  input  logic              eval,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              seq_wr,
  input  logic [WORD_W-1:0] seq_data,
  output logic              fits,
  output logic              last_now,
  output logic [WIDE_W-1:0] buf_ptr,
  output logic [WIDE_W-1:0] buf_words,
  output logic [WIDE_W-1:0] pkt_ptr,
  output logic [LEN_W:0]    pkt_len,
  output logic [WORD_W-1:0] seq
);
  localparam int unsigned SL_W  = LEN_W + 1;
  localparam int unsigned CAP_W = WIDE_W + 1;

  function automatic logic [SL_W-1:0] stored_len(input logic [LEN_W-1:0] l);
    return {1'b0, l} + SL_W'(4);
  endfunction

  function automatic logic [SL_W-1:0] padded_len(input logic [LEN_W-1:0] l, input logic w);
    logic [SL_W-1:0] r;
    if (w) begin
      r = stored_len(l) + SL_W'(3);
      return {r[SL_W-1:2], 2'b00};
    end
    r = stored_len(l) + SL_W'(1);
    return {r[SL_W-1:1], 1'b0};
  endfunction

  logic [SL_W-1:0]   pad;
  logic [WIDE_W-1:0] words_after;
  logic [WIDE_W-1:0] ptr_q, words_q, pkt_ptr_q;
  logic [LEN_W:0]    pkt_len_q;
  logic [WORD_W-1:0] seq_q;

  assign pad         = padded_len(frame_len, wide);
  assign fits        = CAP_W'(pad) <= {words_q, 1'b0};
  assign words_after = words_q - WIDE_W'(pad >> 1);
  assign last_now    = !fits || (words_after < WIDE_W'(eob));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      words_q   <= '0;
      pkt_ptr_q <= '0;
      pkt_len_q <= '0;
      seq_q     <= '0;
    end else begin
      if (load) begin
        ptr_q   <= load_addr;
        words_q <= load_count;
      end else if (eval && fits) begin
        ptr_q     <= ptr_q + WIDE_W'(pad);
        words_q   <= words_after;
        pkt_ptr_q <= ptr_q;
        pkt_len_q <= stored_len(frame_len);
      end
      if (seq_wr) seq_q <= seq_data;
      else if (eval && fits) seq_q <= {seq_q[WORD_W-1:8], seq_q[7:0] + 8'd1};
    end
  end

  assign buf_ptr   = ptr_q;
  assign buf_words = words_q;
  assign pkt_ptr   = pkt_ptr_q;
  assign pkt_len   = pkt_len_q;
  assign seq       = seq_q;

  assert_seq_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && fits && !seq_wr) |=> (seq_q[7:0] == $past(seq_q[7:0]) + 8'd1 &&
                                   seq_q[WORD_W-1:8] == $past(seq_q[WORD_W-1:8])));
  assert_refused_keeps_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !fits && !load) |=> ($stable(words_q) && $stable(ptr_q)));
endmodule

// File: rtl/rx_ring_mgr.sv
`timescale 1ns/1ps
module rx_ring_mgr
  import rx_ring_pkg::*;
#(
  parameter int unsigned       LEN_W     = 16,
  parameter logic [WORD_W-1:0] EOB_RESET = 16'h02F8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              frm_req,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              frm_ready,
  output logic              frm_done,
  output logic              frm_stored,
  output logic              frm_last,
  output logic [WIDE_W-1:0] pkt_ptr,
  output logic [LEN_W:0]    pkt_len,
  output logic [WORD_W-1:0] seq_no,
  output logic [WIDE_W-1:0] buf_ptr,
  output logic [WIDE_W-1:0] buf_words,
  output logic [WORD_W-1:0] rd_ptr,
  output logic              stat_overflow,
  output logic              stat_exhaust,
  output logic              rx_blocked
);
  // named internal events
  logic              fetch_busy, fetch_done, fetch_start;
  logic [WIDE_W-1:0] res_addr, res_count;
  logic [WORD_W-1:0] wr_ptr, eob;
  logic              exhaust_evt;
  logic              frm_go, eval, fits, last_now;
  logic              cmd_fetch, clr_exh, clr_ovf, refill_evt, block_evt;
  logic              pend_q, blocked_q, ovf_q, exh_q;
  logic              done_q, stored_q, last_q;

  assign frm_ready   = !fetch_busy && !pend_q;
  assign frm_go      = frm_req && frm_ready;
  assign eval        = frm_go && !blocked_q;
  assign fetch_start = !fetch_busy && pend_q;
  assign cmd_fetch   = reg_wr && reg_sel == SEL_CMD && reg_wdata[0];
  assign clr_ovf     = reg_wr && reg_sel == SEL_STAT && reg_wdata[ST_OVF_BIT];
  assign clr_exh     = reg_wr && reg_sel == SEL_STAT && reg_wdata[ST_EXH_BIT] && exh_q;
  assign refill_evt  = eval && last_now && (rd_ptr != wr_ptr);
  assign block_evt   = eval && last_now && (rd_ptr == wr_ptr);

  rx_ring_ptrs #(.EOB_RESET(EOB_RESET)) ptrs_i (
    .clk, .rst_n, .wide(mode_wide), .wr_en(reg_wr), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .adv(fetch_done), .rd_ptr, .wr_ptr, .eob, .exhaust_evt
  );

  rx_ring_fetch fetch_i (
    .clk, .rst_n, .start(fetch_start), .wide(mode_wide), .base(rd_ptr),
    .mem_req, .mem_addr, .mem_ack, .mem_rdata, .busy(fetch_busy),
    .done(fetch_done), .res_addr, .res_count
  );

  rx_ring_acct #(.LEN_W(LEN_W)) acct_i (
    .clk, .rst_n, .wide(mode_wide), .eob, .load(fetch_done),
    .load_addr(res_addr), .load_count(res_count), .eval, .frame_len(frm_len),
    .seq_wr(reg_wr && reg_sel == SEL_SEQ), .seq_data(reg_wdata),
    .fits, .last_now, .buf_ptr, .buf_words, .pkt_ptr, .pkt_len, .seq(seq_no)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      blocked_q <= 1'b0;
      ovf_q     <= 1'b0;
      exh_q     <= 1'b0;
      done_q    <= 1'b0;
      stored_q  <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      if (fetch_start) pend_q <= 1'b0;
      if (cmd_fetch || clr_exh || refill_evt) pend_q <= 1'b1;
      if (fetch_done) blocked_q <= 1'b0;
      else if (block_evt) blocked_q <= 1'b1;
      if (clr_ovf) ovf_q <= 1'b0;
      if (eval && !fits) ovf_q <= 1'b1;
      if (clr_exh) exh_q <= 1'b0;
      if (exhaust_evt) exh_q <= 1'b1;
      done_q   <= frm_go;
      stored_q <= eval && fits;
      last_q   <= eval && last_now;
    end
  end

  assign frm_done      = done_q;
  assign frm_stored    = stored_q;
  assign frm_last      = last_q;
  assign stat_overflow = ovf_q;
  assign stat_exhaust  = exh_q;
  assign rx_blocked    = blocked_q;

  assert_done_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> $past(frm_req && frm_ready));
  assert_block_on_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_blocked) |-> $past(rd_ptr == wr_ptr));
  assert_drop_when_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_go && rx_blocked) |=> (frm_done && !frm_stored && !frm_last));
  assert_fetch_unblocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !rx_blocked);
  assert_overflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !fits) |=> (stat_overflow && frm_last && !frm_stored));
endmodule

// File: tb/rx_ring_mgr_tb_top.sv
`timescale 1ns/1ps
module rx_ring_mgr_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        mode_wide = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = 16'd0;
  logic        frm_req = 1'b0;
  logic [15:0] frm_len = 16'd0;
  logic        frm_ready, frm_done, frm_stored, frm_last;
  logic [31:0] pkt_ptr, buf_ptr, buf_words;
  logic [16:0] pkt_len;
  logic [15:0] seq_no, rd_ptr;
  logic        stat_overflow, stat_exhaust, rx_blocked;

  rx_ring_mgr dut_i (
    .clk, .rst_n, .mode_wide, .reg_wr, .reg_sel, .reg_wdata, .mem_req, .mem_addr,
    .mem_ack, .mem_rdata, .frm_req, .frm_len, .frm_ready, .frm_done, .frm_stored,
    .frm_last, .pkt_ptr, .pkt_len, .seq_no, .buf_ptr, .buf_words, .rd_ptr,
    .stat_overflow, .stat_exhaust, .rx_blocked
  );

  // word memory, one cycle response
  logic [15:0] mem [0:255];
  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[8:1]];
  end

  int errors = 0;
  int checks = 0;

  // reference model state
  logic [31:0] m_start, m_end, m_rd, m_wr, m_eob, m_bufp, m_words, m_seq;
  bit m_ovf, m_exh, m_blk, m_wide;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!frm_ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk("R12 ready returns", {31'd0, frm_ready}, 32'd1);
  endtask

  task automatic check_state();
    chk("R4 read pointer", {16'd0, rd_ptr}, m_rd);
    chk("R3 buffer pointer", buf_ptr, m_bufp);
    chk("R8 word count", buf_words, m_words);
    chk("R7 overflow status", {31'd0, stat_overflow}, {31'd0, m_ovf});
    chk("R5 exhaust status", {31'd0, stat_exhaust}, {31'd0, m_exh});
    chk("R10 blocked", {31'd0, rx_blocked}, {31'd0, m_blk});
    chk("R8 sequence", {16'd0, seq_no}, m_seq);
  endtask

  task automatic model_fetch();
    logic [31:0] step;
    logic [15:0] w [4];
    step = m_wide ? 32'd4 : 32'd2;
    for (int k = 0; k < 4; k++) w[k] = mem[((m_rd + k * step) >> 1) & 32'hFF];
    m_bufp  = {w[1], w[0]};
    m_words = {w[3], w[2]};
    m_rd    = (m_rd + 4 * step) & 32'hFFFF;
    if (m_rd == m_end) m_rd = m_start;
    if (m_rd == m_wr) m_exh = 1'b1;
    m_blk = 1'b0;
  endtask

  function automatic logic [31:0] align(input logic [31:0] v);
    return m_wide ? (v & 32'hFFFC) : (v & 32'hFFFE);
  endfunction

  task automatic write_reg(input logic [2:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
    case (sel)
      3'd0: m_start = align({16'd0, data});
      3'd1: m_end   = align({16'd0, data});
      3'd2: m_rd    = align({16'd0, data});
      3'd3: m_wr    = align({16'd0, data});
      3'd4: m_eob   = {16'd0, data};
      3'd5: begin
        if (data[4]) m_ovf = 1'b0;
        if (data[5] && m_exh) begin m_exh = 1'b0; model_fetch(); end
      end
      3'd6: if (data[0]) model_fetch();
      default: m_seq = {16'd0, data};
    endcase
    wait_ready();
  endtask

  task automatic send_frame(input int len);
    logic [31:0] st, pd, e_ptr;
    bit e_st, e_last;
    wait_ready();
    st = len + 4; e_ptr = 0; e_st = 0; e_last = 0;
    pd = m_wide ? ((st + 3) & ~32'd3) : ((st + 1) & ~32'd1);
    if (!m_blk) begin
      if (pd > 2 * m_words) begin
        m_ovf = 1'b1; e_last = 1'b1;
      end else begin
        e_ptr = m_bufp; m_bufp = m_bufp + pd; m_words = m_words - pd / 2;
        m_seq = {16'd0, m_seq[15:8], m_seq[7:0] + 8'd1};
        e_st = 1'b1; e_last = (m_words < m_eob);
      end
      if (e_last) begin
        if (m_rd == m_wr) m_blk = 1'b1;
        else model_fetch();
      end
    end
    @(negedge clk);
    frm_req = 1'b1; frm_len = len[15:0];
    @(negedge clk);
    frm_req = 1'b0;
    chk("R12 done pulse", {31'd0, frm_done}, 32'd1);
    chk("R7 R10 stored flag", {31'd0, frm_stored}, {31'd0, e_st});
    chk("R9 last flag", {31'd0, frm_last}, {31'd0, e_last});
    if (e_st) begin
      chk("R8 packet pointer", pkt_ptr, e_ptr);
      chk("R6 packet length", {15'd0, pkt_len}, st);
    end
    wait_ready();
    chk("R6 padded advance", buf_ptr, m_bufp);
    check_state();
  endtask

  task automatic put_entry(input int word_idx, input logic [31:0] a, input logic [31:0] c, input int stride);
    mem[word_idx]              = a[15:0];
    mem[word_idx + stride]     = a[31:16];
    mem[word_idx + 2 * stride] = c[15:0];
    mem[word_idx + 3 * stride] = c[31:16];
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'd0;
    m_start = 0; m_end = 0; m_rd = 0; m_wr = 0; m_eob = 32'h02F8;
    m_bufp = 0; m_words = 0; m_seq = 0;
    m_ovf = 0; m_exh = 0; m_blk = 0; m_wide = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, frm_ready}, 32'd1);
    chk("R1 mem idle", {31'd0, mem_req}, 32'd0);
    check_state();

    put_entry(16'h40 >> 1, 32'h0001_1000, 32'h0000_0100, 1);
    put_entry(16'h48 >> 1, 32'h0002_2000, 32'h0000_0010, 1);
    put_entry(16'h50 >> 1, 32'h0003_3000, 32'h0000_0040, 1);
    put_entry(16'h58 >> 1, 32'h0004_4000, 32'h0001_0000, 1);

    write_reg(3'd0, 16'h0040);
    write_reg(3'd1, 16'h0060);
    write_reg(3'd2, 16'h0041);
    chk("R2 narrow masking", {16'd0, rd_ptr}, 32'h40);
    write_reg(3'd3, 16'h0059);
    write_reg(3'd4, 16'h0020);
    write_reg(3'd6, 16'h0001);          // R3 R4 command read
    check_state();

    send_frame(60);                      // even, no pad
    send_frame(61);                      // odd, padded
    send_frame(300);                     // leaves 39 words, above threshold (R9)
    send_frame(20);                      // below threshold, next read
    send_frame(40);                      // too big: overflow, read lands on write ptr (R5)
    send_frame(100);                     // last with rd==wr: blocked (R10)
    send_frame(10);                      // dropped while blocked
    write_reg(3'd5, 16'h0010);           // R11 clear overflow only: no read
    chk("R11 no read on bit4", {31'd0, rx_blocked}, 32'd1);
    check_state();
    write_reg(3'd5, 16'h0020);           // R11 clear exhausted: read, wrap (R4)
    chk("R11 unblocked", {31'd0, rx_blocked}, 32'd0);
    chk("R4 wrap to start", {16'd0, rd_ptr}, 32'h40);
    check_state();

    write_reg(3'd7, 16'hABFE);
    send_frame(28);
    send_frame(29);
    chk("R8 low byte wrap", {16'd0, seq_no}, 32'hAB00);

    // 32-bit mode
    @(negedge clk);
    mode_wide = 1'b1; m_wide = 1'b1;
    put_entry(16'h44 >> 1, 32'h0005_5000, 32'h0000_0200, 2);
    write_reg(3'd2, 16'h0047);
    chk("R2 wide masking", {16'd0, rd_ptr}, 32'h44);
    write_reg(3'd3, 16'h0056);
    write_reg(3'd6, 16'h0001);
    chk("R5 wide exhaust", {31'd0, stat_exhaust}, 32'd1);
    check_state();
    send_frame(61);
    send_frame(62);
    send_frame(64);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule